// File: doc/BRIEF.md
# Deskew Delay Calibration Controller

This controller sets the code of a secondary delay line. That delay line cancels the delay added by the clock extraction and equalization path of a delay-locked receiver. The calibration aims for the extraction-path delay plus the deskew delay to add up to two unit intervals. The adjustable deskew range covers roughly half a unit interval to two unit intervals at the target rate.

Calibration runs while the training flag is high. The code starts at zero, which is the shortest delay. The controller then looks at a monitor bit, which is the data sample taken by one fixed phase of the main delay line. While that sample reads 1, the code climbs by one step. The first time the sample reads 0, the code stops. The main loop's lock flag also freezes the code at once. The frozen code keeps driving the delay DAC until reset.

After each step the new code needs time to pass through the DAC and the delay cells before the monitor sample means anything. So the monitor is only judged once every `SETTLE_CYC` cycles. If the code reaches its top value while the monitor still reads 1, the code stops there and a range-error flag is raised.

Top module: `dskcal_ctrl`

## Requirements
- R1: After reset the code is 0, and done and range-error are both 0.
- R2: While training is high and the code is not frozen, the monitor is judged on every `SETTLE_CYC`-th clock edge, counted from the start of training or from the last step. A judged value of 1 below the top code raises the code by exactly 1 on that edge.
- R3: A judged monitor value of 0 freezes the code at its current value and sets done on that same edge.
- R4: When lock is high at an edge and the code is not yet frozen, the code freezes at its current value and done is set. This applies whether or not training is high. Lock wins over a step and over a range error in the same cycle.
- R5: A judged monitor value of 1 at the top code (all ones) freezes the code there and sets both done and range-error on that edge.
- R6: While training is low, the code holds. The settle count restarts, so after training resumes the first judgement comes `SETTLE_CYC` edges later.
- R7: Done and range-error stay set, and the code no longer changes, whatever train, lock and monitor do, until reset.
- R8: The code never decreases and changes by at most 1 per clock edge.
- R9: Range-error is never set without done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| train_i | input | 1 | Training period flag; the search runs only while this is high |
| lock_i | input | 1 | Main delay-loop lock flag; freezes the code |
| mon_i | input | 1 | Monitor data sample from the fixed main-line phase |
| code_o | output | CODE_W | Delay code driving the deskew DAC |
| done_o | output | 1 | Code frozen, sticky until reset |
| range_err_o | output | 1 | Top code reached with the monitor still high, sticky |

## Verification
Two events can land on the same clock edge: the main loop's lock arriving and a monitor judgement. That judgement can be a pending step, a monitor fall, or the top-code range condition. The bench raises lock after every edge count from 0 to 40. This makes lock fall on both judgement and non-judgement edges. It also raises lock exactly on the judgement edge at the top code. In each case the frozen code must equal the number of whole settle periods completed before lock, and range-error must stay clear. This shows that lock takes precedence and that no step slipped through on the shared edge.

// File: rtl/dskcal_pkg.sv
package dskcal_pkg;

  typedef enum logic {
    PH_SEEK = 1'b0,
    PH_HELD = 1'b1
  } seek_phase_t;

  typedef struct packed {
    logic step;
    logic hold;
    logic range_hit;
  } decision_t;

  // Decision for one cycle: lock wins over everything, then the judged monitor.
  function automatic decision_t decide(input logic seeking, input logic lock,
                                       input logic judge, input logic mon,
                                       input logic at_max);
    decision_t d;
    d = '0;
    if (seeking) begin
      if (lock) begin
        d.hold = 1'b1;
      end else if (judge) begin
        if (!mon) begin
          d.hold = 1'b1;
        end else if (at_max) begin
          d.hold      = 1'b1;
          d.range_hit = 1'b1;
        end else begin
          d.step = 1'b1;
        end
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/dskcal_settle_timer.sv
module dskcal_settle_timer #(
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic restart_i,
  output logic ready_o
);
  localparam int unsigned TW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [TW-1:0] LAST = TW'(SETTLE_CYC - 1);

  logic [TW-1:0] tmr_q;
  logic          at_last;

  assign at_last = (tmr_q == LAST);
  assign ready_o = run_i && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               tmr_q <= '0;
    else if (!run_i)          tmr_q <= '0;
    else if (restart_i)       tmr_q <= '0;
    else if (!at_last)        tmr_q <= tmr_q + TW'(1);
  end

  // R2: a step restarts the settle window, so no judgement on the next edge unless the window is one cycle
  assert_settle_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && run_i && SETTLE_CYC > 1) |=> !ready_o);

endmodule

// File: rtl/dskcal_code_ctr.sv
module dskcal_code_ctr #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  output logic [CODE_W-1:0] code_o,
  output logic              at_max_o
);
  localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};

  function automatic logic [CODE_W-1:0] bump(input logic [CODE_W-1:0] c);
    return (c == CODE_TOP) ? c : c + CODE_W'(1);
  endfunction

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (step_i) code_q <= bump(code_q);
  end

  assign code_o   = code_q;
  assign at_max_o = (code_q == CODE_TOP);

  // R5: the decision logic never requests a step at the top code
  assert_no_step_at_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> !at_max_o);

  // R2: a step raises the code by exactly one
  assert_step_plus_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> code_q == $past(code_q) + CODE_W'(1));

endmodule

// File: rtl/dskcal_seek_fsm.sv
module dskcal_seek_fsm
  import dskcal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic train_i,
  input  logic lock_i,
  input  logic mon_i,
  input  logic ready_i,
  input  logic at_max_i,
  output logic run_o,
  output logic step_o,
  output logic done_o,
  output logic err_o
);
  seek_phase_t phase_q;
  logic        err_q;
  logic        seeking;
  decision_t   dec;

  assign seeking = (phase_q == PH_SEEK);
  assign run_o   = seeking && train_i;
  assign dec     = decide(seeking, lock_i, ready_i, mon_i, at_max_i);
  assign step_o  = dec.step;
  assign done_o  = (phase_q == PH_HELD);
  assign err_o   = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SEEK;
      err_q   <= 1'b0;
    end else begin
      if (dec.hold)      phase_q <= PH_HELD;
      if (dec.range_hit) err_q   <= 1'b1;
    end
  end

  // R9: a range error always comes with done
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  // R7: done and range-error are sticky
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);

  // R6: no judgement is possible while training is low
  assert_no_judge_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !train_i |-> !ready_i);

endmodule

// File: rtl/dskcal_ctrl.sv
module dskcal_ctrl #(
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              train_i,
  input  logic              lock_i,
  input  logic              mon_i,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o,
  output logic              range_err_o
);
  logic run_w;
  logic step_w;
  logic ready_w;
  logic at_max_w;

  dskcal_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_w),
    .restart_i (step_w),
    .ready_o   (ready_w)
  );

  dskcal_seek_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .train_i  (train_i),
    .lock_i   (lock_i),
    .mon_i    (mon_i),
    .ready_i  (ready_w),
    .at_max_i (at_max_w),
    .run_o    (run_w),
    .step_o   (step_w),
    .done_o   (done_o),
    .err_o    (range_err_o)
  );

  dskcal_code_ctr #(.CODE_W(CODE_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_i   (step_w),
    .code_o   (code_o),
    .at_max_o (at_max_w)
  );

  // R8: monotonic, at most one step per edge
  assert_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o == $past(code_o)) || (code_o == $past(code_o) + CODE_W'(1)));

  // R4: lock freezes the current code on the edge it is seen
  assert_lock_freezes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_i && !done_o) |=> (done_o && code_o == $past(code_o) && !range_err_o));

  // R7: the code is stable once frozen
  assert_frozen_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> $stable(code_o));

  // R6: the code holds while training is low
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !train_i |=> $stable(code_o));

endmodule

// File: tb/dskcal_ctrl_tb.sv
module dskcal_ctrl_tb;
  localparam int unsigned CW = 8;
  localparam int unsigned SW = 2;
  localparam int TOP = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          train = 1'b0;
  logic          lock = 1'b0;
  logic          mon = 1'b0;
  logic [CW-1:0] code;
  logic          done;
  logic          err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int thr    = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dskcal_ctrl #(.CODE_W(CW), .SETTLE_CYC(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .train_i(train), .lock_i(lock), .mon_i(mon),
    .code_o(code), .done_o(done), .range_err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // behavioural delay model: monitor reads 1 until the code reaches the threshold
  task automatic drive_mon();
    mon = (int'(code) < thr);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; train = 1'b0; lock = 1'b0; mon = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      drive_mon();
    end
  endtask

  task automatic run_to_done(output int n);
    n = 0;
    while (!done && n < 2000) begin
      edges(1);
      n++;
    end
  endtask

  initial begin
    int n;
    int expc;
    do_reset();
    @(negedge clk);
    chk(code == 0, "R1 reset code", code, 0);
    chk(done == 0, "R1 reset done", done, 0);
    chk(err == 0,  "R1 reset err", err, 0);

    // R2 R3 R5: exhaustive threshold sweep, 256 means the monitor never falls
    for (int k = 0; k <= TOP + 1; k++) begin
      do_reset();
      thr = k; train = 1'b1; drive_mon();
      run_to_done(n);
      expc = (k > TOP) ? TOP : k;
      chk(int'(code) == expc, "R3 frozen code", code, expc);
      chk(n == (expc + 1) * SW, "R2 edges to done", n, (expc + 1) * SW);
      chk(done == 1'b1, "R3 done set", done, 1);
      chk(int'(err) == ((k > TOP) ? 1 : 0), "R5 range error", err, (k > TOP) ? 1 : 0);
    end

    // R4: lock after every edge count, hitting judgement and non-judgement edges
    for (int m = 0; m <= 40; m++) begin
      do_reset();
      thr = 200; train = 1'b1; drive_mon();
      edges(m);
      lock = 1'b1;
      edges(1);
      lock = 1'b0;
      chk(int'(code) == m / SW, "R4 lock freeze code", code, m / SW);
      chk(done == 1'b1 && err == 1'b0, "R4 lock done no err", {done, err}, 2);
    end

    // R4 vs R5: lock on the judgement edge at the top code
    do_reset();
    thr = TOP + 1; train = 1'b1; drive_mon();
    edges((TOP + 1) * SW - 1);
    lock = 1'b1;
    edges(1);
    lock = 1'b0;
    chk(int'(code) == TOP, "R4 lock at top code", code, TOP);
    chk(err == 1'b0, "R4 lock beats range error", err, 0);

    // R6: training gap restarts the settle window
    do_reset();
    thr = 50; train = 1'b1; drive_mon();
    edges(11);
    train = 1'b0;
    edges(7);
    chk(code == 5, "R6 code holds idle", code, 5);
    chk(done == 0, "R6 no done idle", done, 0);
    train = 1'b1;
    run_to_done(n);
    chk(code == 50, "R6 resumed final code", code, 50);
    chk(n == 92, "R6 edges after resume", n, 92);

    // R4: lock while training is low
    do_reset();
    thr = 50; train = 1'b1; drive_mon();
    edges(10);
    train = 1'b0; lock = 1'b1;
    edges(1);
    lock = 1'b0;
    chk(done == 1 && code == 5, "R4 lock while idle", code, 5);

    // R7: frozen state ignores all inputs
    do_reset();
    thr = 30; train = 1'b1; drive_mon();
    run_to_done(n);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      mon = i[0]; train = i[1]; lock = i[2];
      @(posedge clk);
      @(negedge clk);
      chk(code == 30 && done == 1, "R7 frozen code", code, 30);
    end
    lock = 1'b0;
    do_reset();
    thr = TOP + 1; train = 1'b1; drive_mon();
    run_to_done(n);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      mon = i[0]; train = i[1]; lock = i[2];
      @(posedge clk);
      @(negedge clk);
      chk(err == 1 && int'(code) == TOP, "R7 sticky range error", err, 1);
    end

    // R1: reset mid-search
    lock = 1'b0;
    do_reset();
    thr = 100; train = 1'b1; drive_mon();
    edges(40);
    rst_n = 1'b0;
    @(negedge clk);
    chk(code == 0 && done == 0 && err == 0, "R1 reset mid-run", code, 0);
    rst_n = 1'b1;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 190000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule